// File: doc/BRIEF.md
# Vertical-Blank Interrupt Controller

This block follows the raster position of a video unit and turns it into a vertical-blank indication for a host processor. A dot counter and a scanline counter advance once per clock, one clock per video dot. At a fixed point near the end of the visible picture, the block arms an internal pending bit. On the next dot that bit becomes the visible vertical-blank flag. Two dots after that, the interrupt line toward the host goes high if interrupts are enabled. The flag and the line are cleared on the first dot of the last scanline. On odd frames, when both background and sprite rendering are enabled, the last scanline is one dot shorter.

The host reaches the block through two single-cycle strobes that share one 8-bit data bus. The control write loads the interrupt enable and the video control fields. The status read returns the flag together with two sprite status inputs and the low bits of the last byte written. A status read clears the flag. It also drops the interrupt line and pulses a clear toward the neighbouring register that owns the two-write address toggle. The host treats the line as edge-triggered, so every 0-to-1 transition counts as one interrupt.

Top module: `vbn_nmi_ctrl`

## Requirements
- R1: After reset the dot counter runs from 0 to DOTS-1 and the scanline counter from 0 to LINES-1. Each wraps to 0, and the scanline advances when the dot wraps. A frame with no skip therefore lasts DOTS*LINES clocks.
- R2: A frame-parity bit starts even after reset and toggles at each frame wrap. When the parity is odd on the last scanline, both rendering enables are sampled on the clock at dot DOTS-3. If both are high there, dot DOTS-1 of that scanline is skipped. The frame is then one clock short, and enable changes after the sampling dot do not alter that decision.
- R3: The pending bit is set on the clock at (VBL_LINE-1, DOTS-1). On the clock at (VBL_LINE, 0) the flag takes the value of the pending bit.
- R4: On the clock at (VBL_LINE, 2) the interrupt line is loaded with the interrupt enable ANDed with the flag.
- R5: On the clock at (LINES-1, 0) the flag is cleared and the interrupt line is driven low.
- R6: One clock after a status read, `status_q` holds the flag as it stood before the read in bit 7, sprite-zero-hit in bit 6 and sprite overflow in bit 5. Bits 4:0 are the data-bus latch. Between reads `status_q` holds its value.
- R7: A status read clears the pending bit and the flag, drives the interrupt line low on the next clock, and raises `toggle_clr` for exactly that one clock.
- R8: A status read takes priority over a flag event on the same clock. A read at the arming dot or at the flag dot returns 0 in bit 7, and no flag and no interrupt follow in that frame. A read at (VBL_LINE, 1) returns 1, and no interrupt follows.
- R9: Control-write bit 7 is the interrupt enable. On the same clock the interrupt line is recomputed as the new enable ANDed with the current flag. Enabling during vertical blank with the flag set therefore raises the line, and disabling lowers it.
- R10: Control-write bits 1:0 load `taddr` bits 11:10, and the other `taddr` bits keep their value. Bit 2 drives `step32`, bit 3 `spr_tbl_hi`, bit 4 `bg_tbl_hi`, bit 5 `spr_tall` and bit 6 `ext_mode`.
- R11: The data-bus latch takes bits 4:0 of every control write and keeps them until the next write.
- R12: While reset is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock, one video dot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rd_status | input | 1 | Status-read strobe, one cycle |
| wr_ctrl | input | 1 | Control-write strobe, one cycle |
| din | input | 8 | Host write data |
| bg_en | input | 1 | Background rendering enabled |
| spr_en | input | 1 | Sprite rendering enabled |
| spr0_hit | input | 1 | Sprite-zero-hit status |
| spr_ovf | input | 1 | Sprite overflow status |
| status_q | output | 8 | Status byte captured by the last read |
| nmi | output | 1 | Interrupt request line, active high |
| dot_pos | output | $clog2(DOTS) | Current dot |
| line_pos | output | $clog2(LINES) | Current scanline |
| nmi_en | output | 1 | Interrupt enable field |
| ext_mode | output | 1 | External master/slave select field |
| spr_tall | output | 1 | Tall sprite size field |
| bg_tbl_hi | output | 1 | Background pattern base at 0x1000 |
| spr_tbl_hi | output | 1 | Sprite pattern base at 0x1000 |
| step32 | output | 1 | Address step of 32 instead of 1 |
| taddr | output | 15 | Temporary address register |
| toggle_clr | output | 1 | One-cycle clear for the write-pair toggle |

## Verification
Every output is a register. A strobe or counter position presented on one clock edge therefore shows up after that edge: `status_q`, `nmi`, `toggle_clr` and the control fields one cycle after the strobe, and the flag events on the edge where the counter equals the event position. The bench steps to a position by watching `dot_pos` and `line_pos`. It drives the strobe for one edge and reads the outputs at the following falling edge. A read at the flag dot, for example, is checked against the value from before the event. Frame lengths are counted in clocks between two arrivals at position (0,0), so the odd-frame skip shows up as a count of one less.

// File: rtl/vbn_pkg.sv
package vbn_pkg;

  typedef struct packed {
    logic nmi_en;
    logic ext_mode;
    logic spr_tall;
    logic bg_tbl_hi;
    logic spr_tbl_hi;
    logic step32;
  } vbn_ctrl_t;

  typedef struct packed {
    logic arm;
    logic show;
    logic raise;
    logic clear;
  } vbn_evt_t;

  localparam int TADDR_W = 15;
  localparam int LATCH_W = 5;

endpackage

// File: rtl/vbn_raster.sv
module vbn_raster
  import vbn_pkg::*;
#(
  parameter int DOTS        = 341,
  parameter int LINES       = 262,
  parameter int VBL_LINE    = 241,
  parameter int RAISE_DELAY = 2,
  parameter int DW          = $clog2(DOTS),
  parameter int LW          = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bg_en,
  input  logic          spr_en,
  output logic [DW-1:0] dot_q,
  output logic [LW-1:0] line_q,
  output vbn_evt_t      evt
);

  localparam logic [DW-1:0] DOT_LAST   = DW'(DOTS - 1);
  localparam logic [DW-1:0] DOT_SKIPAT = DW'(DOTS - 2);
  localparam logic [DW-1:0] DOT_SAMPLE = DW'(DOTS - 3);
  localparam logic [DW-1:0] DOT_RAISE  = DW'(RAISE_DELAY);
  localparam logic [LW-1:0] LINE_LAST  = LW'(LINES - 1);
  localparam logic [LW-1:0] LINE_ARM   = LW'(VBL_LINE - 1);
  localparam logic [LW-1:0] LINE_VBL   = LW'(VBL_LINE);

  logic odd_q;
  logic skip_q;
  logic on_last;
  logic dot_wrap;

  assign on_last  = (line_q == LINE_LAST);
  assign dot_wrap = (dot_q == DOT_LAST) || (on_last && skip_q && dot_q == DOT_SKIPAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      dot_q  <= '0;
      line_q <= '0;
      odd_q  <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      if (on_last && dot_q == DOT_SAMPLE)
        skip_q <= odd_q & bg_en & spr_en;
      if (dot_wrap) begin
        dot_q <= '0;
        if (on_last) begin
          line_q <= '0;
          odd_q  <= ~odd_q;
          skip_q <= 1'b0;
        end else begin
          line_q <= line_q + 1'b1;
        end
      end else begin
        dot_q <= dot_q + 1'b1;
      end
    end
  end

  always_comb begin
    evt.arm   = (line_q == LINE_ARM) && (dot_q == DOT_LAST);
    evt.show  = (line_q == LINE_VBL) && (dot_q == '0);
    evt.raise = (line_q == LINE_VBL) && (dot_q == DOT_RAISE);
    evt.clear = on_last && (dot_q == '0);
  end

endmodule

// File: rtl/vbn_ctrl_reg.sv
module vbn_ctrl_reg
  import vbn_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [7:0]         din,
  output vbn_ctrl_t          ctrl_q,
  output logic [TADDR_W-1:0] taddr_q,
  output logic [LATCH_W-1:0] bus_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      taddr_q <= '0;
      bus_q   <= '0;
    end else if (wr) begin
      ctrl_q.nmi_en     <= din[7];
      ctrl_q.ext_mode   <= din[6];
      ctrl_q.spr_tall   <= din[5];
      ctrl_q.bg_tbl_hi  <= din[4];
      ctrl_q.spr_tbl_hi <= din[3];
      ctrl_q.step32     <= din[2];
      taddr_q[11:10]    <= din[1:0];
      bus_q             <= din[LATCH_W-1:0];
    end
  end

endmodule

// File: rtl/vbn_vblank.sv
module vbn_vblank
  import vbn_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  vbn_evt_t           evt,
  input  logic               rd,
  input  logic               wr,
  input  logic               wr_en_bit,
  input  logic               cur_en,
  input  logic               spr0_hit,
  input  logic               spr_ovf,
  input  logic [LATCH_W-1:0] bus_latch,
  output logic [7:0]         status_q,
  output logic               nmi_q,
  output logic               toggle_clr_q
);

  logic pend_q;
  logic flag_q;

  // Priority, highest first: status read, end-of-blank clear, control write, raise dot.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q       <= 1'b0;
      flag_q       <= 1'b0;
      nmi_q        <= 1'b0;
      status_q     <= '0;
      toggle_clr_q <= 1'b0;
    end else begin
      toggle_clr_q <= rd;
      if (rd)
        status_q <= {flag_q, spr0_hit, spr_ovf, bus_latch};

      if (rd)             pend_q <= 1'b0;
      else if (evt.arm)   pend_q <= 1'b1;
      else if (evt.clear) pend_q <= 1'b0;

      if (rd)             flag_q <= 1'b0;
      else if (evt.clear) flag_q <= 1'b0;
      else if (evt.show)  flag_q <= pend_q;

      if (rd)             nmi_q <= 1'b0;
      else if (evt.clear) nmi_q <= 1'b0;
      else if (wr)        nmi_q <= wr_en_bit & flag_q;
      else if (evt.raise) nmi_q <= cur_en & flag_q;
    end
  end

endmodule

// File: rtl/vbn_nmi_ctrl.sv
module vbn_nmi_ctrl
  import vbn_pkg::*;
#(
  parameter int DOTS        = 341,
  parameter int LINES       = 262,
  parameter int VBL_LINE    = 241,
  parameter int RAISE_DELAY = 2,
  parameter int DW          = $clog2(DOTS),
  parameter int LW          = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_status,
  input  logic          wr_ctrl,
  input  logic [7:0]    din,
  input  logic          bg_en,
  input  logic          spr_en,
  input  logic          spr0_hit,
  input  logic          spr_ovf,
  output logic [7:0]    status_q,
  output logic          nmi,
  output logic [DW-1:0] dot_pos,
  output logic [LW-1:0] line_pos,
  output logic          nmi_en,
  output logic          ext_mode,
  output logic          spr_tall,
  output logic          bg_tbl_hi,
  output logic          spr_tbl_hi,
  output logic          step32,
  output logic [14:0]   taddr,
  output logic          toggle_clr
);

  vbn_evt_t           evt;
  vbn_ctrl_t          ctrl;
  logic [LATCH_W-1:0] bus_latch;

  vbn_raster #(
    .DOTS(DOTS), .LINES(LINES), .VBL_LINE(VBL_LINE),
    .RAISE_DELAY(RAISE_DELAY), .DW(DW), .LW(LW)
  ) u_raster (
    .clk(clk), .rst(rst), .bg_en(bg_en), .spr_en(spr_en),
    .dot_q(dot_pos), .line_q(line_pos), .evt(evt)
  );

  vbn_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr(wr_ctrl), .din(din),
    .ctrl_q(ctrl), .taddr_q(taddr), .bus_q(bus_latch)
  );

  vbn_vblank u_vbl (
    .clk(clk), .rst(rst), .evt(evt), .rd(rd_status), .wr(wr_ctrl),
    .wr_en_bit(din[7]), .cur_en(ctrl.nmi_en),
    .spr0_hit(spr0_hit), .spr_ovf(spr_ovf), .bus_latch(bus_latch),
    .status_q(status_q), .nmi_q(nmi), .toggle_clr_q(toggle_clr)
  );

  assign nmi_en     = ctrl.nmi_en;
  assign ext_mode   = ctrl.ext_mode;
  assign spr_tall   = ctrl.spr_tall;
  assign bg_tbl_hi  = ctrl.bg_tbl_hi;
  assign spr_tbl_hi = ctrl.spr_tbl_hi;
  assign step32     = ctrl.step32;

endmodule

// File: rtl/vbn_nmi_chk.sv
module vbn_nmi_chk #(
  parameter int DOTS        = 341,
  parameter int LINES       = 262,
  parameter int VBL_LINE    = 241,
  parameter int RAISE_DELAY = 2,
  parameter int DW          = $clog2(DOTS),
  parameter int LW          = $clog2(LINES)
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_status,
  input logic          wr_ctrl,
  input logic [7:0]    status_q,
  input logic          nmi,
  input logic          nmi_en,
  input logic          toggle_clr,
  input logic [DW-1:0] dot_pos,
  input logic [LW-1:0] line_pos
);

  localparam logic [DW-1:0] C_DOT_LAST  = DW'(DOTS - 1);
  localparam logic [DW-1:0] C_DOT_SKIP  = DW'(DOTS - 2);
  localparam logic [DW-1:0] C_DOT_RAISE = DW'(RAISE_DELAY);
  localparam logic [LW-1:0] C_LINE_LAST = LW'(LINES - 1);
  localparam logic [LW-1:0] C_LINE_VBL  = LW'(VBL_LINE);

  AST_DOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && dot_pos != '0) |-> (dot_pos == $past(dot_pos) + 1'b1)); // R1
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && dot_pos != '0) |-> $stable(line_pos)); // R1
  AST_SHORT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && dot_pos == '0 && $past(dot_pos) != C_DOT_LAST)
      |-> ($past(line_pos) == C_LINE_LAST && $past(dot_pos) == C_DOT_SKIP)); // R2
  AST_RISE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi) |-> ($past(wr_ctrl)
      || ($past(line_pos) == C_LINE_VBL && $past(dot_pos) == C_DOT_RAISE))); // R4
  AST_END_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (line_pos == C_LINE_LAST && dot_pos == '0) |=> !nmi); // R5
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_status |=> $stable(status_q)); // R6
  AST_READ_DROP: assert property (@(posedge clk) disable iff (rst)
    rd_status |=> !nmi); // R7
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_status |=> toggle_clr); // R7
  AST_NMI_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    nmi |-> nmi_en); // R9

endmodule

bind vbn_nmi_ctrl vbn_nmi_chk #(
  .DOTS(DOTS), .LINES(LINES), .VBL_LINE(VBL_LINE),
  .RAISE_DELAY(RAISE_DELAY), .DW(DW), .LW(LW)
) u_chk (
  .clk(clk), .rst(rst), .rd_status(rd_status), .wr_ctrl(wr_ctrl),
  .status_q(status_q), .nmi(nmi), .nmi_en(nmi_en), .toggle_clr(toggle_clr),
  .dot_pos(dot_pos), .line_pos(line_pos)
);

// File: tb/vbn_nmi_ctrl_bench.sv
`timescale 1ns/1ps
module vbn_nmi_ctrl_bench;

  localparam int DOTS  = 16;
  localparam int LINES = 12;
  localparam int VBL   = 9;
  localparam int DW    = $clog2(DOTS);
  localparam int LW    = $clog2(LINES);
  localparam int FRAME = DOTS * LINES;
  localparam int WDOG  = 60000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_status = 1'b0;
  logic          wr_ctrl = 1'b0;
  logic [7:0]    din = '0;
  logic          bg_en = 1'b0;
  logic          spr_en = 1'b0;
  logic          spr0_hit = 1'b0;
  logic          spr_ovf = 1'b0;
  logic [7:0]    status_q;
  logic          nmi;
  logic [DW-1:0] dot_pos;
  logic [LW-1:0] line_pos;
  logic          nmi_en, ext_mode, spr_tall, bg_tbl_hi, spr_tbl_hi, step32;
  logic [14:0]   taddr;
  logic          toggle_clr;

  int total = 0;
  int fails = 0;
  int steps = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  vbn_nmi_ctrl #(.DOTS(DOTS), .LINES(LINES), .VBL_LINE(VBL)) u_vbn_nmi_ctrl (
    .clk(clk), .rst(rst), .rd_status(rd_status), .wr_ctrl(wr_ctrl), .din(din),
    .bg_en(bg_en), .spr_en(spr_en), .spr0_hit(spr0_hit), .spr_ovf(spr_ovf),
    .status_q(status_q), .nmi(nmi), .dot_pos(dot_pos), .line_pos(line_pos),
    .nmi_en(nmi_en), .ext_mode(ext_mode), .spr_tall(spr_tall),
    .bg_tbl_hi(bg_tbl_hi), .spr_tbl_hi(spr_tbl_hi), .step32(step32),
    .taddr(taddr), .toggle_clr(toggle_clr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG && !done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL R1 watchdog: actual=hung expected=progress");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    steps++;
  endtask

  task automatic go_to(input int l, input int d);
    while (!(int'(line_pos) == l && int'(dot_pos) == d)) step();
  endtask

  task automatic do_read();
    rd_status = 1'b1;
    step();
    rd_status = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] v);
    wr_ctrl = 1'b1;
    din = v;
    step();
    wr_ctrl = 1'b0;
  endtask

  task automatic reset_dut();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
  endtask

  // fields: [32:29] req, [28:27] op (0 watch, 1 read, 2 write), [26:19] line,
  //         [18:10] dot, [9:2] data, [1] expected nmi, [0] expected status bit 7
  localparam int NV = 19;
  localparam logic [32:0] VEC [NV] = '{
    {4'd9, 2'd2, 8'd0,  9'd5,  8'h80, 1'b0, 1'b0}, // R9 enable outside blank
    {4'd4, 2'd0, 8'd9,  9'd1,  8'h00, 1'b0, 1'b0}, // R4 not yet raised
    {4'd4, 2'd0, 8'd9,  9'd2,  8'h00, 1'b1, 1'b0}, // R4 raised two dots after flag
    {4'd6, 2'd1, 8'd9,  9'd5,  8'h00, 1'b0, 1'b1}, // R6 R3 flag read as 1
    {4'd7, 2'd1, 8'd9,  9'd6,  8'h00, 1'b0, 1'b0}, // R7 flag cleared by read
    {4'd9, 2'd2, 8'd3,  9'd0,  8'h00, 1'b0, 1'b0}, // R9 disable
    {4'd9, 2'd0, 8'd9,  9'd3,  8'h00, 1'b0, 1'b0}, // R9 no raise when disabled
    {4'd9, 2'd2, 8'd9,  9'd8,  8'h80, 1'b1, 1'b0}, // R9 enable with flag set
    {4'd9, 2'd2, 8'd9,  9'd9,  8'h00, 1'b0, 1'b0}, // R9 disable drops line
    {4'd9, 2'd2, 8'd9,  9'd10, 8'h80, 1'b1, 1'b0}, // R9 re-enable raises again
    {4'd5, 2'd0, 8'd11, 9'd0,  8'h00, 1'b0, 1'b0}, // R5 end of blank
    {4'd5, 2'd1, 8'd11, 9'd1,  8'h00, 1'b0, 1'b0}, // R5 flag cleared
    {4'd8, 2'd1, 8'd8,  9'd15, 8'h00, 1'b0, 1'b0}, // R8 read on arming dot
    {4'd8, 2'd0, 8'd9,  9'd3,  8'h00, 1'b0, 1'b0}, // R8 no interrupt follows
    {4'd8, 2'd1, 8'd9,  9'd4,  8'h00, 1'b0, 1'b0}, // R8 flag never set
    {4'd8, 2'd1, 8'd9,  9'd0,  8'h00, 1'b0, 1'b0}, // R8 read on flag dot
    {4'd8, 2'd0, 8'd9,  9'd3,  8'h00, 1'b0, 1'b0}, // R8 no interrupt follows
    {4'd3, 2'd1, 8'd9,  9'd1,  8'h00, 1'b0, 1'b1}, // R3 flag seen one dot after set
    {4'd4, 2'd0, 8'd9,  9'd3,  8'h00, 1'b0, 1'b0}  // R4 read before raise dot
  };

  initial begin
    int s0;
    string tag;

    // R12 reset state
    repeat (2) step();
    chk("R12 status", status_q, 8'h00);
    chk("R12 nmi", nmi, 1'b0);
    chk("R12 position", {dot_pos, line_pos}, '0);
    chk("R12 fields", {nmi_en, ext_mode, spr_tall, bg_tbl_hi, spr_tbl_hi, step32, toggle_clr}, 7'd0);
    chk("R12 taddr", taddr, 15'd0);
    rst = 1'b0;

    // R1 dot wrap advances scanline
    go_to(0, DOTS - 1);
    step();
    chk("R1 wrap", {28'd0, line_pos, dot_pos}, {28'd0, LW'(1), DW'(0)});

    // R1 R2 frame lengths after a fresh reset
    reset_dut();
    bg_en = 1'b1; spr_en = 1'b1;
    s0 = steps; step(); go_to(0, 0);
    chk("R1 even frame length", steps - s0, FRAME);
    s0 = steps; go_to(LINES - 1, DOTS - 2); spr_en = 1'b0; go_to(0, 0);
    chk("R2 odd skip kept after late disable", steps - s0, FRAME - 1);
    s0 = steps; step(); go_to(0, 0);
    chk("R1 even frame one enable", steps - s0, FRAME);
    s0 = steps; step(); go_to(0, 0);
    chk("R2 odd frame one enable", steps - s0, FRAME);
    spr_en = 1'b1;
    s0 = steps; step(); go_to(0, 0);
    chk("R2 even frame no skip", steps - s0, FRAME);
    s0 = steps; go_to(LINES - 1, DOTS - 3); spr_en = 1'b0; go_to(0, 0);
    chk("R2 odd disabled on sample dot", steps - s0, FRAME);
    s0 = steps; step(); go_to(0, 0);
    chk("R1 even frame", steps - s0, FRAME);
    s0 = steps; go_to(LINES - 1, DOTS - 3); spr_en = 1'b1; go_to(0, 0);
    chk("R2 odd enabled on sample dot", steps - s0, FRAME - 1);

    // table walk, rendering off
    bg_en = 1'b0; spr_en = 1'b0;
    reset_dut();
    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[32:29], i);
      go_to(int'(v[26:19]), int'(v[18:10]));
      if (v[28:27] == 2'd1) do_read();
      else if (v[28:27] == 2'd2) do_write(v[9:2]);
      else step();
      chk({tag, " nmi"}, nmi, v[1]);
      if (v[28:27] == 2'd1) chk({tag, " flag"}, status_q[7], v[0]);
    end

    // R10 R11 R6 R7 directed
    go_to(2, 0);
    do_write(8'h15);
    chk("R10 fields 15", {nmi_en, ext_mode, spr_tall, bg_tbl_hi, spr_tbl_hi, step32}, 6'b000101);
    chk("R10 taddr 15", taddr, 15'h0400);
    spr0_hit = 1'b1; spr_ovf = 1'b0;
    do_read();
    chk("R6 R11 status 55", status_q, 8'h55);
    chk("R7 toggle pulse", toggle_clr, 1'b1);
    step();
    chk("R7 toggle one cycle", toggle_clr, 1'b0);
    chk("R6 status holds", status_q, 8'h55);
    do_write(8'hEA);
    chk("R10 fields EA", {nmi_en, ext_mode, spr_tall, bg_tbl_hi, spr_tbl_hi, step32}, 6'b111010);
    chk("R10 taddr EA", taddr, 15'h0800);
    spr0_hit = 1'b0; spr_ovf = 1'b1;
    do_read();
    chk("R6 R11 status 2A", status_q, 8'h2A);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule